// File: doc/BRIEF.md
# In-Flight Instruction Squash and Retire Tracker

This block keeps, for every hardware thread of an in-order pipeline, a program-ordered list of the instructions currently in flight. Each entry holds only the per-thread sequence number handed out when the instruction was allocated; sequence numbers begin at 1 after reset and grow by one per accepted allocation. Instruction contents, register dependencies and cache behaviour are handled elsewhere.

Three kinds of request shrink a list. A retire removes the oldest entry of a thread. A squash removes younger entries in one of three flavours: younger than a given sequence number, a memory-stall squash that also removes the stalling instruction, or a whole-thread flush. Every entry hit by a request in a cycle is marked in a per-entry "queued for removal" vector. All marked entries are released together at the clock edge that closes the cycle, and an entry hit by two requests is released only once. With the same edge, a registered per-stage kill mask is presented to the pipeline together with the thread and the sequence bound, so that each stage can drop its own copies.

Allocation is a valid/ready stream. A beat transfers when `alloc_valid` and `alloc_ready` are both high at a rising edge. `alloc_ready` is low when the target thread's list is full, or when a squash aims at that same thread in that cycle. The producer must then hold the beat and keep its fields stable. Retire and squash are plain single-cycle strobes.

Top module: `inflight_squash_tracker`

## Requirements
- R1: After reset every thread count is 0, the oldest and youngest outputs read 0, the kill mask is 0, every non-speculative flag is 0, and `alloc_seq` reads 1 for every thread.
- R2: An accepted allocation appends an entry whose sequence number equals the value shown on `alloc_seq` for that thread before the edge. That value starts at 1 and increases by one per accepted allocation of that thread. It is never reused after squashes.
- R3: `alloc_ready` is 0 when the target thread holds DEPTH (16) entries, or when a squash request (kinds 0 to 2) names the same thread in that cycle. A beat offered while `alloc_ready` is 0 changes nothing.
- R4: A squash of kind 0 (younger-than) with bound B removes, at the next edge, every entry of the thread whose sequence number is greater than B. The scan runs from youngest to oldest and stops at the first entry not greater than B.
- R5: A squash of kind 1 (memory stall) with sequence N (N ≥ 1) uses the bound N−1, so the entry N itself is removed. Its kill mask has bits 0 through S set, where S is `sq_stage`; all bits are set when S ≥ the stage count.
- R6: A squash of kind 2 (whole thread) removes every entry of the thread and sets all kill mask bits. Kind 3 is no request: it removes nothing and leaves the kill mask at 0.
- R7: A squash or retire changes only the list of the thread it names.
- R8: A retire removes the oldest entry of the named thread. A retire of an empty thread has no effect.
- R9: When a retire and a squash hit the same thread in the same cycle, each entry hit by either is removed exactly once. The count falls by the size of the union of the two hit sets.
- R10: The kill mask (bit s = stage s), `kill_tid` and `kill_bound` are registered: they show a request one cycle after it is presented, for exactly one cycle. Kind 0 sets all mask bits. The mask is 0 in cycles that follow no request.
- R11: Allocating with `alloc_nonspec` high while the thread's non-speculative flag is clear sets the flag and records that sequence number. The flag clears when the recorded entry is removed, whether by retire or by squash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation beat offered |
| alloc_ready | output | 1 | Allocation beat can be accepted |
| alloc_tid | input | TID_W | Thread of the allocation |
| alloc_nonspec | input | 1 | Allocated instruction is non-speculative |
| alloc_seq | output | SEQ_W | Sequence number the next allocation of `alloc_tid` gets |
| retire_valid | input | 1 | Retire oldest entry strobe |
| retire_tid | input | TID_W | Thread to retire from |
| sq_valid | input | 1 | Squash request strobe |
| sq_kind | input | 2 | 0 younger-than, 1 memory stall, 2 whole thread, 3 none |
| sq_tid | input | TID_W | Thread to squash |
| sq_seq | input | SEQ_W | Sequence bound (kind 0) or stalling instruction (kind 1) |
| sq_stage | input | STG_W | Stalling stage (kind 1) |
| kill_stages | output | NUM_STAGES | Registered per-stage kill mask |
| kill_tid | output | TID_W | Thread of the registered kill |
| kill_bound | output | SEQ_W | Kill entries younger than this bound |
| thr_count | output | NUM_THREADS*CNT_W | Per-thread entry count, thread t at bits t*CNT_W |
| thr_oldest | output | NUM_THREADS*SEQ_W | Per-thread oldest sequence number, 0 if empty |
| thr_youngest | output | NUM_THREADS*SEQ_W | Per-thread youngest sequence number, 0 if empty |
| nonspec_active | output | NUM_THREADS | Per-thread non-speculative flag |

## Verification
A retire and a squash can strike the same thread in one cycle, and the oldest entry can be in both hit sets. The bench provokes this in two ways. It pairs a retire with a squash that covers the whole list, which must leave the list empty rather than wrap the count. It also pairs a retire with a squash of only the youngest entry, which must leave exactly the middle entry as both oldest and youngest. After each case, a fresh allocation shows whether the head and count stayed consistent.

// File: rtl/sqt_pkg.sv
`timescale 1ns/1ps
package sqt_pkg;
  typedef enum logic [1:0] {
    SQ_YOUNGER  = 2'd0,
    SQ_MEMSTALL = 2'd1,
    SQ_THREAD   = 2'd2,
    SQ_NONE     = 2'd3
  } sq_kind_e;
endpackage

// File: rtl/sqt_thread_list.sv
`timescale 1ns/1ps
module sqt_thread_list #(
  parameter int DEPTH = 16,
  parameter int SEQ_W = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic             alloc_nonspec,
  input  logic             sq_en,
  input  logic [SEQ_W-1:0] sq_bound,
  input  logic             retire_en,
  output logic [SEQ_W-1:0] next_seq_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic [SEQ_W-1:0] oldest_o,
  output logic [SEQ_W-1:0] youngest_o,
  output logic             nonspec_o
);
  logic [SEQ_W-1:0] seq_mem [DEPTH];
  logic [PTR_W-1:0] head_q;
  logic [CNT_W-1:0] count_q;
  logic [SEQ_W-1:0] nxt_seq_q, ns_seq_q;
  logic             ns_flag_q;

  logic [PTR_W-1:0] slot [DEPTH];
  logic [DEPTH-1:0] sq_mark, rt_mark, queued;
  logic             scan_run, lead_run, ns_hit;
  logic [CNT_W-1:0] free_cnt, lead_cnt, keep_cnt;
  logic [PTR_W-1:0] new_head, wr_slot;

  always_comb begin
    for (int j = 0; j < DEPTH; j++) slot[j] = head_q + PTR_W'(j);
  end

  // youngest-to-oldest scan, stops at first entry not above the bound
  always_comb begin
    sq_mark  = '0;
    scan_run = 1'b1;
    for (int j = DEPTH - 1; j >= 0; j--) begin
      if (CNT_W'(j) < count_q) begin
        if (scan_run && sq_en && (seq_mem[slot[j]] > sq_bound)) sq_mark[j] = 1'b1;
        else scan_run = 1'b0;
      end
    end
  end

  always_comb begin
    rt_mark    = '0;
    rt_mark[0] = retire_en && (count_q != '0);
  end

  // union of hit sets: an entry hit twice is queued once
  assign queued   = sq_mark | rt_mark;
  assign free_cnt = CNT_W'($countones(queued));
  assign keep_cnt = count_q - free_cnt;

  always_comb begin
    lead_cnt = '0;
    lead_run = 1'b1;
    ns_hit   = 1'b0;
    for (int j = 0; j < DEPTH; j++) begin
      if (lead_run && queued[j]) lead_cnt = lead_cnt + 1'b1;
      else lead_run = 1'b0;
      if (queued[j] && ns_flag_q && (seq_mem[slot[j]] == ns_seq_q)) ns_hit = 1'b1;
    end
  end

  assign new_head = head_q + PTR_W'(lead_cnt);
  assign wr_slot  = new_head + PTR_W'(keep_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q    <= '0;
      count_q   <= '0;
      nxt_seq_q <= SEQ_W'(1);
      ns_flag_q <= 1'b0;
      ns_seq_q  <= '0;
    end else begin
      head_q  <= new_head;
      count_q <= keep_cnt + CNT_W'(alloc_en);
      if (alloc_en) nxt_seq_q <= nxt_seq_q + 1'b1;
      if (alloc_en && alloc_nonspec && (!ns_flag_q || ns_hit)) begin
        ns_flag_q <= 1'b1;
        ns_seq_q  <= nxt_seq_q;
      end else if (ns_hit) begin
        ns_flag_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) seq_mem[wr_slot] <= nxt_seq_q;
  end

  assign next_seq_o = nxt_seq_q;
  assign count_o    = count_q;
  assign full_o     = (count_q == CNT_W'(DEPTH));
  assign oldest_o   = (count_q != '0) ? seq_mem[head_q] : '0;
  assign youngest_o = (count_q != '0) ? seq_mem[head_q + PTR_W'(count_q - 1'b1)] : '0;
  assign nonspec_o  = ns_flag_q;

  p_alloc_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> (count_q < CNT_W'(DEPTH)));
  p_no_alloc_in_squash_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !sq_en);
  p_youngest_is_new_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> (youngest_o == $past(next_seq_o)));
  p_squash_shrinks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_en && !alloc_en) |=> (count_o <= $past(count_o)));
  p_retire_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_en && !sq_en && !alloc_en && count_o != '0) |=> (count_o == $past(count_o) - 1'b1));
endmodule

// File: rtl/sqt_kill_gen.sv
`timescale 1ns/1ps
module sqt_kill_gen
  import sqt_pkg::*;
#(
  parameter int NUM_STAGES = 5,
  parameter int SEQ_W      = 16,
  parameter int TID_W      = 1,
  localparam int STG_W     = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic [1:0]            kind,
  input  logic [STG_W-1:0]      stage,
  input  logic [TID_W-1:0]      tid,
  input  logic [SEQ_W-1:0]      bound,
  output logic [NUM_STAGES-1:0] kill_o,
  output logic [TID_W-1:0]      kill_tid_o,
  output logic [SEQ_W-1:0]      kill_bound_o
);
  logic [NUM_STAGES-1:0] mask_c;

  // memory-stall kills the stalling stage and all earlier ones
  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    assign mask_c[g] = (sq_kind_e'(kind) == SQ_MEMSTALL) ? (STG_W'(g) <= stage) : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kill_o       <= '0;
      kill_tid_o   <= '0;
      kill_bound_o <= '0;
    end else begin
      kill_o       <= req ? mask_c : '0;
      kill_tid_o   <= req ? tid : '0;
      kill_bound_o <= req ? bound : '0;
    end
  end

  p_kill_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (kill_o != '0));
  p_kill_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (kill_o == '0));
  p_thread_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && sq_kind_e'(kind) == SQ_THREAD) |=> (&kill_o));
  p_stall_stage0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && sq_kind_e'(kind) == SQ_MEMSTALL) |=> kill_o[0]);
endmodule

// File: rtl/inflight_squash_tracker.sv
`timescale 1ns/1ps
module inflight_squash_tracker
  import sqt_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int DEPTH       = 16,
  parameter int SEQ_W       = 16,
  parameter int NUM_STAGES  = 5,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int STG_W      = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         alloc_valid,
  output logic                         alloc_ready,
  input  logic [TID_W-1:0]             alloc_tid,
  input  logic                         alloc_nonspec,
  output logic [SEQ_W-1:0]             alloc_seq,
  input  logic                         retire_valid,
  input  logic [TID_W-1:0]             retire_tid,
  input  logic                         sq_valid,
  input  logic [1:0]                   sq_kind,
  input  logic [TID_W-1:0]             sq_tid,
  input  logic [SEQ_W-1:0]             sq_seq,
  input  logic [STG_W-1:0]             sq_stage,
  output logic [NUM_STAGES-1:0]        kill_stages,
  output logic [TID_W-1:0]             kill_tid,
  output logic [SEQ_W-1:0]             kill_bound,
  output logic [NUM_THREADS*CNT_W-1:0] thr_count,
  output logic [NUM_THREADS*SEQ_W-1:0] thr_oldest,
  output logic [NUM_THREADS*SEQ_W-1:0] thr_youngest,
  output logic [NUM_THREADS-1:0]       nonspec_active
);
  logic             sq_go;
  logic [SEQ_W-1:0] sq_bound;
  logic [SEQ_W-1:0] next_seq_a [NUM_THREADS];
  logic             full_a     [NUM_THREADS];

  assign sq_go = sq_valid && (sq_kind_e'(sq_kind) != SQ_NONE);

  always_comb begin
    case (sq_kind_e'(sq_kind))
      SQ_MEMSTALL: sq_bound = sq_seq - 1'b1;  // stalling instruction included
      SQ_THREAD:   sq_bound = '0;
      default:     sq_bound = sq_seq;
    endcase
  end

  assign alloc_ready = !full_a[alloc_tid] && !(sq_go && (sq_tid == alloc_tid));
  assign alloc_seq   = next_seq_a[alloc_tid];

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic t_alloc, t_sq, t_ret;
    assign t_alloc = alloc_valid && alloc_ready && (alloc_tid == TID_W'(t));
    assign t_sq    = sq_go && (sq_tid == TID_W'(t));
    assign t_ret   = retire_valid && (retire_tid == TID_W'(t));

    sqt_thread_list #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_list (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_en     (t_alloc),
      .alloc_nonspec(alloc_nonspec),
      .sq_en        (t_sq),
      .sq_bound     (sq_bound),
      .retire_en    (t_ret),
      .next_seq_o   (next_seq_a[t]),
      .count_o      (thr_count[t*CNT_W +: CNT_W]),
      .full_o       (full_a[t]),
      .oldest_o     (thr_oldest[t*SEQ_W +: SEQ_W]),
      .youngest_o   (thr_youngest[t*SEQ_W +: SEQ_W]),
      .nonspec_o    (nonspec_active[t])
    );
  end

  sqt_kill_gen #(.NUM_STAGES(NUM_STAGES), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_kill (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (sq_go),
    .kind        (sq_kind),
    .stage       (sq_stage),
    .tid         (sq_tid),
    .bound       (sq_bound),
    .kill_o      (kill_stages),
    .kill_tid_o  (kill_tid),
    .kill_bound_o(kill_bound)
  );

  p_tid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sq_go |=> (kill_tid == $past(sq_tid)));
endmodule

// File: tb/inflight_squash_tracker_tb_top.sv
`timescale 1ns/1ps
module inflight_squash_tracker_tb_top;
  localparam int T = 2, CW = 5, SW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid, alloc_ready, alloc_tid, alloc_nonspec;
  logic [15:0] alloc_seq;
  logic retire_valid, retire_tid, sq_valid, sq_tid;
  logic [1:0] sq_kind;
  logic [15:0] sq_seq;
  logic [2:0] sq_stage;
  logic [4:0] kill_stages;
  logic kill_tid;
  logic [15:0] kill_bound;
  logic [T*CW-1:0] thr_count;
  logic [T*SW-1:0] thr_oldest, thr_youngest;
  logic [T-1:0] nonspec_active;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  inflight_squash_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_tid(alloc_tid), .alloc_nonspec(alloc_nonspec), .alloc_seq(alloc_seq),
    .retire_valid(retire_valid), .retire_tid(retire_tid), .sq_valid(sq_valid),
    .sq_kind(sq_kind), .sq_tid(sq_tid), .sq_seq(sq_seq), .sq_stage(sq_stage),
    .kill_stages(kill_stages), .kill_tid(kill_tid), .kill_bound(kill_bound),
    .thr_count(thr_count), .thr_oldest(thr_oldest), .thr_youngest(thr_youngest),
    .nonspec_active(nonspec_active));

  typedef struct packed {
    logic [1:0] op;   // 0 idle, 1 alloc, 2 retire, 3 squash
    logic       tid;
    logic [1:0] kind;
    logic [15:0] seq;
    logic [2:0] stg;
    logic [4:0] c0, c1;
    logic [15:0] o0, y0;
    logic [4:0] kl;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{2'd1,1'b0,2'd0,16'd0,3'd0,5'd1,5'd0,16'd1,16'd1,5'd0},
    '{2'd1,1'b0,2'd0,16'd0,3'd0,5'd2,5'd0,16'd1,16'd2,5'd0},
    '{2'd1,1'b0,2'd0,16'd0,3'd0,5'd3,5'd0,16'd1,16'd3,5'd0},
    '{2'd1,1'b0,2'd0,16'd0,3'd0,5'd4,5'd0,16'd1,16'd4,5'd0},
    '{2'd1,1'b0,2'd0,16'd0,3'd0,5'd5,5'd0,16'd1,16'd5,5'd0},
    '{2'd1,1'b1,2'd0,16'd0,3'd0,5'd5,5'd1,16'd1,16'd5,5'd0},
    '{2'd1,1'b1,2'd0,16'd0,3'd0,5'd5,5'd2,16'd1,16'd5,5'd0},
    '{2'd3,1'b0,2'd0,16'd3,3'd0,5'd3,5'd2,16'd1,16'd3,5'd31},
    '{2'd0,1'b0,2'd0,16'd0,3'd0,5'd3,5'd2,16'd1,16'd3,5'd0},
    '{2'd1,1'b0,2'd0,16'd0,3'd0,5'd4,5'd2,16'd1,16'd6,5'd0},
    '{2'd3,1'b0,2'd1,16'd6,3'd2,5'd3,5'd2,16'd1,16'd3,5'd7},
    '{2'd3,1'b0,2'd1,16'd2,3'd0,5'd1,5'd2,16'd1,16'd1,5'd1},
    '{2'd2,1'b0,2'd0,16'd0,3'd0,5'd0,5'd2,16'd0,16'd0,5'd0},
    '{2'd2,1'b0,2'd0,16'd0,3'd0,5'd0,5'd2,16'd0,16'd0,5'd0},
    '{2'd1,1'b0,2'd0,16'd0,3'd0,5'd1,5'd2,16'd7,16'd7,5'd0},
    '{2'd3,1'b1,2'd2,16'd0,3'd0,5'd1,5'd0,16'd7,16'd7,5'd31},
    '{2'd3,1'b0,2'd0,16'd7,3'd0,5'd1,5'd0,16'd7,16'd7,5'd31},
    '{2'd1,1'b1,2'd0,16'd0,3'd0,5'd1,5'd1,16'd7,16'd7,5'd0},
    '{2'd3,1'b0,2'd3,16'd0,3'd0,5'd1,5'd1,16'd7,16'd7,5'd0}
  };

  function automatic int cnt(int t);  return int'(thr_count[t*CW +: CW]);    endfunction
  function automatic int old(int t);  return int'(thr_oldest[t*SW +: SW]);   endfunction
  function automatic int yng(int t);  return int'(thr_youngest[t*SW +: SW]); endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chkv(string req, int act, int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic idle();
    alloc_valid = 0; alloc_tid = 0; alloc_nonspec = 0;
    retire_valid = 0; retire_tid = 0;
    sq_valid = 0; sq_kind = 0; sq_tid = 0; sq_seq = 0; sq_stage = 0;
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic do_reset();
    idle(); rst_n = 0; tick(); tick(); rst_n = 1;
  endtask

  task automatic alloc(bit t, bit ns);
    idle(); alloc_valid = 1; alloc_tid = t; alloc_nonspec = ns; tick(); idle();
  endtask

  initial begin
    idle();
    do_reset();
    // R1 reset state
    chkv("R1 count t0", cnt(0), 0);
    chkv("R1 count t1", cnt(1), 0);
    chkv("R1 oldest t0", old(0), 0);
    chkv("R1 kill", int'(kill_stages), 0);
    chkv("R1 nonspec", int'(nonspec_active), 0);
    alloc_tid = 1; #1;
    chkv("R1 R2 first seq t1", int'(alloc_seq), 1);
    chkv("R1 ready", int'(alloc_ready), 1);
    alloc_tid = 0; #1;
    chkv("R1 R2 first seq t0", int'(alloc_seq), 1);

    // vector walk: R2 R4 R5 R6 R7 R8 R10
    for (int i = 0; i < NV; i++) begin
      idle();
      case (VEC[i].op)
        2'd1: begin alloc_valid = 1; alloc_tid = VEC[i].tid; end
        2'd2: begin retire_valid = 1; retire_tid = VEC[i].tid; end
        2'd3: begin sq_valid = 1; sq_tid = VEC[i].tid; sq_kind = VEC[i].kind;
                    sq_seq = VEC[i].seq; sq_stage = VEC[i].stg; end
        default: ;
      endcase
      tick();
      chkv($sformatf("R4 R5 R8 vec%0d count t0", i), cnt(0), int'(VEC[i].c0));
      chkv($sformatf("R7 vec%0d count t1", i), cnt(1), int'(VEC[i].c1));
      chkv($sformatf("R8 vec%0d oldest t0", i), old(0), int'(VEC[i].o0));
      chkv($sformatf("R2 R4 vec%0d youngest t0", i), yng(0), int'(VEC[i].y0));
      chkv($sformatf("R10 R5 R6 vec%0d kill mask", i), int'(kill_stages), int'(VEC[i].kl));
    end
    idle(); tick();

    // R10 kill tid and bound for a memory-stall squash (bound = N-1)
    sq_valid = 1; sq_kind = 2'd1; sq_tid = 1; sq_seq = 16'd9; sq_stage = 3'd6; tick(); idle();
    chkv("R10 kill tid", int'(kill_tid), 1);
    chkv("R5 R10 kill bound", int'(kill_bound), 8);
    chkv("R5 stage beyond last", int'(kill_stages), 31);
    tick();
    chkv("R10 kill one cycle", int'(kill_stages), 0);

    // R3 full and back-pressure
    do_reset();
    for (int k = 0; k < 16; k++) alloc(0, 0);
    chkv("R3 count full", cnt(0), 16);
    alloc_valid = 1; alloc_tid = 0; #1;
    chkv("R3 ready low when full", int'(alloc_ready), 0);
    tick(); idle();
    chkv("R3 count unchanged", cnt(0), 16);
    chkv("R3 youngest unchanged", yng(0), 16);
    alloc_tid = 1; #1;
    chkv("R3 other thread ready", int'(alloc_ready), 1);
    sq_valid = 1; sq_kind = 2'd0; sq_tid = 1; sq_seq = 16'd100; #1;
    chkv("R3 ready low during own squash", int'(alloc_ready), 0);
    alloc_valid = 1; tick(); idle();
    chkv("R3 no alloc during squash", cnt(1), 0);

    // R9 same-cycle squash and retire
    do_reset();
    alloc(0, 0); alloc(0, 0); alloc(0, 0);
    retire_valid = 1; retire_tid = 0;
    sq_valid = 1; sq_kind = 2'd0; sq_tid = 0; sq_seq = 16'd0; tick(); idle();
    chkv("R9 full overlap count", cnt(0), 0);
    alloc(0, 0);
    chkv("R9 after overlap count", cnt(0), 1);
    chkv("R9 after overlap oldest", old(0), 4);
    alloc(0, 0); alloc(0, 0);
    retire_valid = 1; retire_tid = 0;
    sq_valid = 1; sq_kind = 2'd0; sq_tid = 0; sq_seq = 16'd5; tick(); idle();
    chkv("R9 split count", cnt(0), 1);
    chkv("R9 split oldest", old(0), 5);
    chkv("R9 split youngest", yng(0), 5);

    // R11 non-speculative flag
    do_reset();
    alloc(1, 1);
    chkv("R11 flag set t1", int'(nonspec_active), 2);
    alloc(1, 0); alloc(1, 1);
    retire_valid = 1; retire_tid = 1; tick(); idle();
    chkv("R11 cleared by retire", int'(nonspec_active), 0);
    alloc(1, 1);
    chkv("R11 set again", int'(nonspec_active), 2);
    sq_valid = 1; sq_kind = 2'd0; sq_tid = 1; sq_seq = 16'd3; tick(); idle();
    chkv("R11 cleared by squash", int'(nonspec_active), 0);
    chkv("R11 R4 count t1", cnt(1), 2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule